// File: doc/BRIEF.md
# Calibration Pulse Control Sequencer

This block is the digital controller of a multi-channel calibration pulser. It runs from one 40 MHz system clock and keeps three kinds of settings. The first is a 128-bit channel-enable pattern. The second is a 16-bit amplitude code, which goes without pause to the DAC. The third is a pair of fine-delay settings. A controller reads and writes all of these settings through a parallel register port that uses byte addresses. A serial bus slave outside this block normally sits in front of that port.

A small command input carries broadcast timing commands. A fire command opens a calibration window that lasts a fixed number of cycles. The window is gated onto each enabled channel, and every accepted fire command advances a wrapping pulse counter. A reset command gives a one-cycle reset strobe and clears the counter. The command input and the register port never stall, so neither of them has back-pressure. A command or a write that is present at a clock edge is taken at that edge.

Register map. The map uses byte addresses, and a register is selected by `addr[4:2]` only when `addr[1:0]` is zero:
- `0x00`, `0x04`, `0x08` and `0x0C` hold enable words 0 to 3.
- `0x10` holds the amplitude code.
- `0x14` holds the delays.
- `0x18` is the counter. A read returns the count and a write clears it.
- `0x1C` is unused.

Top module: `cal_pulse_ctrl`

## Requirements
- R1: While `rst_n` is low and after it is released, every register and the pulse counter are zero. This means `chan_pulse`, `dac_code`, `delay_a`, `delay_b`, `cal_window` and `reset_pulse` are all zero, and a read of `0x18` returns 0.
- R2: A write to `0x00`, `0x04`, `0x08` or `0x0C` stores enable word k, where k is `addr[3:2]`. Bit i of word k enables channel 32k+i. A read of the same address returns the stored word.
- R3: A write to `0x10` stores `wdata[15:0]` as the amplitude code. `dac_code` shows the code from the cycle after the write and holds it until the next write. A read of `0x10` returns the code with bits 31:16 zero.
- R4: A write to `0x14` sets `delay_a` from `wdata[4:0]` and `delay_b` from `wdata[12:8]`. Any field value above 24 is stored as 24. A read of `0x14` returns the stored fields in the same bit positions, with all other bits zero.
- R5: A command with `cmd_valid` high and `cmd_code` = 2'b01 is a fire command. If `cal_window` is low, it is accepted, and `cal_window` goes high for exactly 4 cycles starting in the cycle after the command. A fire command that arrives while `cal_window` is high is ignored: the window is not extended and the counter does not count it.
- R6: `chan_pulse[n]` equals `cal_window` AND the enable bit of channel n in every cycle.
- R7: Each accepted fire command adds one to the 11-bit pulse counter, and the counter wraps from 2047 to 0. A read of `0x18` returns the count in bits 10:0.
- R8: A command with `cmd_valid` high and `cmd_code` = 2'b10 raises `reset_pulse` for one cycle, in the cycle after the command, and clears the counter. The enable pattern, the amplitude code and the delays do not change.
- R9: Command codes 2'b00 and 2'b11, and any code given while `cmd_valid` is low, have no effect on `cal_window`, `reset_pulse` or the counter.
- R10: A write to `0x18` clears the counter. If a fire command is accepted in the same cycle, the clear takes priority, but the window still opens.
- R11: A read of `0x1C` returns zero and a write to it changes nothing. Any access with `addr[1:0]` not zero reads zero and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 40 MHz system clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| cmd_valid | input | 1 | Strobe that marks a broadcast command |
| cmd_code | input | 2 | Command code: 01 fires, 10 resets, other codes are ignored |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 5 | Byte address of the register |
| reg_wdata | input | 32 | Data to write |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| dac_code | output | 16 | Amplitude code sent to the DAC |
| delay_a | output | 5 | First fine-delay setting, from 0 to 24 |
| delay_b | output | 5 | Second fine-delay setting, from 0 to 24 |
| cal_window | output | 1 | Calibration window |
| reset_pulse | output | 1 | One-cycle reset strobe |
| chan_pulse | output | 128 | Window gated by each channel's enable bit |

## Verification
The counter wrap is the hardest case to reach from the ports. It needs 2048 accepted fire commands, and each one must come only after the previous window has closed, because any fire command sent early is dropped. The stimulus therefore sends a fire command every sixth cycle and checks the count both at the wrap and one pulse after it. The same-cycle collision of a counter clear and an accepted fire, and fire commands sent during the last window cycle, are driven on purpose. A behavioural model checks every output on every clock.

// File: rtl/cal_pulse_pkg.sv
package cal_pulse_pkg;
  typedef enum logic [1:0] {
    CMD_NOP   = 2'b00,
    CMD_FIRE  = 2'b01,
    CMD_RESET = 2'b10,
    CMD_SPARE = 2'b11
  } cal_cmd_e;

  // word indices (address bits [4:2]) of the non-pattern registers
  localparam int unsigned REG_IDX_DAC = 4;
  localparam int unsigned REG_IDX_DLY = 5;
  localparam int unsigned REG_IDX_CNT = 6;
  // bit position of the second delay field inside its register
  localparam int unsigned DLY_B_LSB   = 8;
endpackage

// File: rtl/cal_regfile.sv
module cal_regfile
  import cal_pulse_pkg::*;
#(
  parameter int unsigned NUM_CH  = 128,
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned DAC_W   = 16,
  parameter int unsigned DLY_W   = 5,
  parameter int unsigned DLY_MAX = 24,
  parameter int unsigned CNT_W   = 11,
  parameter int unsigned ADDR_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [CNT_W-1:0]  cnt_val,
  output logic [WORD_W-1:0] rdata,
  output logic [NUM_CH-1:0] enables,
  output logic [DAC_W-1:0]  dac,
  output logic [DLY_W-1:0]  dly_a,
  output logic [DLY_W-1:0]  dly_b,
  output logic              cnt_clr
);
  localparam int unsigned NUM_WORDS = NUM_CH / WORD_W;
  localparam int unsigned IDX_W     = ADDR_W - 2;

  logic [WORD_W-1:0] en_q [NUM_WORDS];
  logic [DAC_W-1:0]  dac_q;
  logic [DLY_W-1:0]  dly_a_q, dly_b_q;
  logic [IDX_W-1:0]  idx;
  logic              aligned;

  assign idx     = addr[ADDR_W-1:2];
  assign aligned = (addr[1:0] == 2'b00);

  function automatic logic [DLY_W-1:0] clamp_dly(input logic [DLY_W-1:0] v);
    return (v > DLY_W'(DLY_MAX)) ? DLY_W'(DLY_MAX) : v;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < NUM_WORDS; w++) en_q[w] <= '0;
      dac_q   <= '0;
      dly_a_q <= '0;
      dly_b_q <= '0;
    end else if (wr && aligned) begin
      for (int w = 0; w < NUM_WORDS; w++)
        if (idx == IDX_W'(w)) en_q[w] <= wdata;
      if (idx == IDX_W'(REG_IDX_DAC)) dac_q <= wdata[DAC_W-1:0];
      if (idx == IDX_W'(REG_IDX_DLY)) begin
        dly_a_q <= clamp_dly(wdata[DLY_W-1:0]);
        dly_b_q <= clamp_dly(wdata[DLY_B_LSB +: DLY_W]);
      end
    end
  end

  assign cnt_clr = wr && aligned && (idx == IDX_W'(REG_IDX_CNT));

  always_comb begin
    rdata = '0;
    if (aligned) begin
      for (int w = 0; w < NUM_WORDS; w++)
        if (idx == IDX_W'(w)) rdata = en_q[w];
      if (idx == IDX_W'(REG_IDX_DAC)) rdata = WORD_W'(dac_q);
      if (idx == IDX_W'(REG_IDX_DLY)) begin
        rdata[DLY_W-1:0]           = dly_a_q;
        rdata[DLY_B_LSB +: DLY_W]  = dly_b_q;
      end
      if (idx == IDX_W'(REG_IDX_CNT)) rdata = WORD_W'(cnt_val);
    end
  end

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_en_word
    assign enables[w*WORD_W +: WORD_W] = en_q[w];
  end

  assign dac   = dac_q;
  assign dly_a = dly_a_q;
  assign dly_b = dly_b_q;
endmodule

// File: rtl/cal_window_gen.sv
module cal_window_gen
  import cal_pulse_pkg::*;
#(
  parameter int unsigned WIN_LEN = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_code,
  output logic       window,
  output logic       fire_accept,
  output logic       reset_cmd,
  output logic       rst_strobe
);
  localparam int unsigned LW = $clog2(WIN_LEN + 1);

  logic [LW-1:0] left_q;
  logic          rst_q;

  assign fire_accept = cmd_valid && (cmd_code == CMD_FIRE) && (left_q == '0);
  assign reset_cmd   = cmd_valid && (cmd_code == CMD_RESET);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
      rst_q  <= 1'b0;
    end else begin
      rst_q <= reset_cmd;
      if (fire_accept)        left_q <= LW'(WIN_LEN);
      else if (left_q != '0)  left_q <= left_q - 1'b1;
    end
  end

  assign window     = (left_q != '0);
  assign rst_strobe = rst_q;
endmodule

// File: rtl/cal_pulse_counter.sv
module cal_pulse_counter #(
  parameter int unsigned CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             incr,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     count_q <= '0;
    else if (clear) count_q <= '0;
    else if (incr)  count_q <= count_q + 1'b1;
  end

  assign count = count_q;
endmodule

// File: rtl/cal_pulse_ctrl.sv
module cal_pulse_ctrl
  import cal_pulse_pkg::*;
#(
  parameter int unsigned NUM_CH  = 128,
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned DAC_W   = 16,
  parameter int unsigned DLY_W   = 5,
  parameter int unsigned DLY_MAX = 24,
  parameter int unsigned CNT_W   = 11,
  parameter int unsigned ADDR_W  = 5,
  parameter int unsigned WIN_LEN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_code,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic [DAC_W-1:0]  dac_code,
  output logic [DLY_W-1:0]  delay_a,
  output logic [DLY_W-1:0]  delay_b,
  output logic              cal_window,
  output logic              reset_pulse,
  output logic [NUM_CH-1:0] chan_pulse
);
  logic [NUM_CH-1:0] enables;
  logic [CNT_W-1:0]  count;
  logic              cnt_clr, fire_accept, reset_cmd;

  cal_regfile #(
    .NUM_CH(NUM_CH), .WORD_W(WORD_W), .DAC_W(DAC_W), .DLY_W(DLY_W),
    .DLY_MAX(DLY_MAX), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .cnt_val(count), .rdata(reg_rdata), .enables(enables), .dac(dac_code),
    .dly_a(delay_a), .dly_b(delay_b), .cnt_clr(cnt_clr)
  );

  cal_window_gen #(.WIN_LEN(WIN_LEN)) u_win (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .window(cal_window), .fire_accept(fire_accept), .reset_cmd(reset_cmd),
    .rst_strobe(reset_pulse)
  );

  cal_pulse_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clear(cnt_clr || reset_cmd),
    .incr(fire_accept), .count(count)
  );

  assign chan_pulse = {NUM_CH{cal_window}} & enables;
endmodule

// File: rtl/cal_pulse_ctrl_chk.sv
module cal_pulse_ctrl_chk #(
  parameter int unsigned NUM_CH  = 128,
  parameter int unsigned DAC_W   = 16,
  parameter int unsigned DLY_W   = 5,
  parameter int unsigned DLY_MAX = 24,
  parameter int unsigned WIN_LEN = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [1:0]        cmd_code,
  input logic              reg_wr,
  input logic [DAC_W-1:0]  dac_code,
  input logic [DLY_W-1:0]  delay_a,
  input logic [DLY_W-1:0]  delay_b,
  input logic              cal_window,
  input logic              reset_pulse,
  input logic [NUM_CH-1:0] chan_pulse
);
  localparam int unsigned RW = $clog2(WIN_LEN + 2) + 1;
  logic [RW-1:0] run_len;

  // number of consecutive high window cycles seen before the current one
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       run_len <= '0;
    else if (!cal_window)             run_len <= '0;
    else if (run_len != {RW{1'b1}})   run_len <= run_len + 1'b1;
  end

  a_r5_window_max: assert property (@(posedge clk) disable iff (!rst_n)
    cal_window |-> (run_len < RW'(WIN_LEN)));
  a_r5_window_full: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cal_window) |-> (run_len == RW'(WIN_LEN)));
  a_r5_window_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cal_window) |-> $past(cmd_valid && cmd_code == 2'b01));
  a_r6_gated_off: assert property (@(posedge clk) disable iff (!rst_n)
    !cal_window |-> (chan_pulse == '0));
  a_r8_reset_cause: assert property (@(posedge clk) disable iff (!rst_n)
    reset_pulse |-> $past(cmd_valid && cmd_code == 2'b10));
  a_r3_dac_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(reg_wr) |-> $stable(dac_code));
  a_r4_delay_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    (delay_a <= DLY_W'(DLY_MAX)) && (delay_b <= DLY_W'(DLY_MAX)));
endmodule

bind cal_pulse_ctrl cal_pulse_ctrl_chk #(
  .NUM_CH(NUM_CH), .DAC_W(DAC_W), .DLY_W(DLY_W), .DLY_MAX(DLY_MAX), .WIN_LEN(WIN_LEN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
  .reg_wr(reg_wr), .dac_code(dac_code), .delay_a(delay_a), .delay_b(delay_b),
  .cal_window(cal_window), .reset_pulse(reset_pulse), .chan_pulse(chan_pulse)
);

// File: tb/test_cal_pulse_ctrl.sv
`timescale 1ns/1ps
module test_cal_pulse_ctrl;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmd_valid = 1'b0;
  logic [1:0]   cmd_code = 2'b00;
  logic         reg_wr = 1'b0;
  logic [4:0]   reg_addr = 5'h00;
  logic [31:0]  reg_wdata = 32'h0;
  logic [31:0]  reg_rdata;
  logic [15:0]  dac_code;
  logic [4:0]   delay_a, delay_b;
  logic         cal_window, reset_pulse;
  logic [127:0] chan_pulse;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cal_pulse_ctrl i_cal_pulse_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .dac_code(dac_code), .delay_a(delay_a), .delay_b(delay_b),
    .cal_window(cal_window), .reset_pulse(reset_pulse), .chan_pulse(chan_pulse)
  );

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_en [4] = '{default: 32'h0};
  int m_dac = 0, m_da = 0, m_db = 0, m_cnt = 0, m_left = 0;
  bit m_rst = 0;

  function automatic int clampv(int v);
    return (v > 24) ? 24 : v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_en[k]) m_en[k] = 32'h0;
      m_dac = 0; m_da = 0; m_db = 0; m_cnt = 0; m_left = 0; m_rst = 0;
    end else begin
      automatic int  idx = int'(reg_addr) / 4;
      automatic bit  al  = (reg_addr % 4) == 0;
      automatic bit  acc = cmd_valid && cmd_code == 2'b01 && m_left == 0;
      automatic bit  clr = 0;
      if (reg_wr && al) begin
        if (idx < 4) m_en[idx] = reg_wdata;
        else if (idx == 4) m_dac = int'(reg_wdata & 32'hFFFF);
        else if (idx == 5) begin
          m_da = clampv(int'(reg_wdata & 32'h1F));
          m_db = clampv(int'((reg_wdata >> 8) & 32'h1F));
        end else if (idx == 6) clr = 1;
      end
      m_rst = cmd_valid && cmd_code == 2'b10;
      if (clr || m_rst) m_cnt = 0;
      else if (acc)     m_cnt = (m_cnt + 1) % 2048;
      if (acc) m_left = 4;
      else if (m_left > 0) m_left--;
    end
  end

  function automatic logic [31:0] exp_rdata();
    automatic int idx = int'(reg_addr) / 4;
    if (reg_addr % 4 != 0) return 32'h0;
    case (idx)
      0, 1, 2, 3: return m_en[idx];
      4: return 32'(m_dac);
      5: return 32'(m_da) | (32'(m_db) << 8);
      6: return 32'(m_cnt);
      default: return 32'h0;
    endcase
  endfunction

  function automatic string rd_tag();
    automatic int idx = int'(reg_addr) / 4;
    if (reg_addr % 4 != 0 || idx == 7) return "R11 rdata";
    if (idx < 4) return "R2 rdata";
    if (idx == 4) return "R3 rdata";
    if (idx == 5) return "R4 rdata";
    return "R7 rdata";
  endfunction

  task automatic chk(input string tag, input logic [127:0] got, input logic [127:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h at %0t", tag, got, exp, $time);
    end
  endtask

  // compare every output against the model on every clock (R1 covers reset cycles)
  always @(negedge clk) begin
    if (!done) begin
      chk("R5 window", 128'(cal_window), 128'(m_left > 0));
      chk("R6 chan_pulse", chan_pulse,
          (m_left > 0) ? {m_en[3], m_en[2], m_en[1], m_en[0]} : 128'h0);
      chk("R3 dac_code", 128'(dac_code), 128'(m_dac));
      chk("R4 delay_a", 128'(delay_a), 128'(m_da));
      chk("R4 delay_b", 128'(delay_b), 128'(m_db));
      chk("R8 reset_pulse", 128'(reset_pulse), 128'(m_rst));
      chk(rd_tag(), 128'(reg_rdata), 128'(exp_rdata()));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired got %0d cycles exp fewer", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    step();
    reg_wr = 0;
  endtask

  task automatic cmd(input logic [1:0] c, input logic v);
    cmd_valid = v; cmd_code = c;
    step();
    cmd_valid = 0; cmd_code = 2'b00;
  endtask

  task automatic rd(input string tag, input logic [4:0] a, input logic [31:0] exp);
    reg_addr = a; #1;
    chk(tag, 128'(reg_rdata), 128'(exp));
  endtask

  initial begin
    repeat (3) step();
    // R1 reset state
    chk("R1 dac_code", 128'(dac_code), 128'h0);
    chk("R1 chan_pulse", chan_pulse, 128'h0);
    rd("R1 count", 5'h18, 32'h0);
    rst_n = 1; step();
    chk("R1 window", 128'(cal_window), 128'h0);

    // R2 pattern words
    wr(5'h00, 32'h0000_0001);
    wr(5'h04, 32'h8000_0000);
    wr(5'h08, 32'hA5A5_5A5A);
    wr(5'h0C, 32'h0000_0000);
    rd("R2 word2", 5'h08, 32'hA5A5_5A5A);
    rd("R2 word1", 5'h04, 32'h8000_0000);

    // R3 amplitude code
    wr(5'h10, 32'hFFFF_BEEF);
    #1 chk("R3 dac_code", 128'(dac_code), 128'hBEEF);
    rd("R3 readback", 5'h10, 32'h0000_BEEF);

    // R4 delays with clamp
    wr(5'h14, 32'h0000_1F07);
    #1 chk("R4 a=7", 128'(delay_a), 128'd7);
    chk("R4 b clamp", 128'(delay_b), 128'd24);
    wr(5'h14, 32'h0000_0C19);
    #1 chk("R4 a clamp", 128'(delay_a), 128'd24);
    chk("R4 b=12", 128'(delay_b), 128'd12);
    rd("R4 readback", 5'h14, 32'h0000_0C18);

    // R5/R6 fire, with a fire during the window (ignored)
    reg_addr = 5'h18;
    cmd(2'b01, 1);
    #1 chk("R5 window open", 128'(cal_window), 128'h1);
    chk("R6 gated", chan_pulse, {32'h0, 32'hA5A5_5A5A, 32'h8000_0000, 32'h0000_0001});
    cmd(2'b01, 1);
    step(); step();
    cmd(2'b01, 1);   // last window cycle: still ignored
    #1 chk("R5 window closed", 128'(cal_window), 128'h0);
    rd("R5 one count", 5'h18, 32'd1);

    // R9 ignored codes
    cmd(2'b00, 1); cmd(2'b11, 1); cmd(2'b01, 0);
    #1 chk("R9 no window", 128'(cal_window), 128'h0);
    rd("R9 count kept", 5'h18, 32'd1);

    // R8 reset command
    cmd(2'b10, 1);
    #1 chk("R8 strobe", 128'(reset_pulse), 128'h1);
    rd("R8 count cleared", 5'h18, 32'd0);
    rd("R8 pattern kept", 5'h08, 32'hA5A5_5A5A);
    step();
    chk("R8 strobe one cycle", 128'(reset_pulse), 128'h0);
    chk("R8 dac kept", 128'(dac_code), 128'hBEEF);

    // R10 clear collides with accepted fire
    cmd(2'b01, 1); repeat (5) step();
    reg_wr = 1; reg_addr = 5'h18; reg_wdata = 32'h0; cmd_valid = 1; cmd_code = 2'b01;
    step();
    reg_wr = 0; cmd_valid = 0; cmd_code = 2'b00;
    #1 chk("R10 window opens", 128'(cal_window), 128'h1);
    rd("R10 clear wins", 5'h18, 32'd0);
    repeat (5) step();

    // R11 unused and misaligned
    wr(5'h1C, 32'hFFFF_FFFF);
    rd("R11 unused reads 0", 5'h1C, 32'h0);
    wr(5'h11, 32'h0000_1234);
    #1 chk("R11 misaligned no write", 128'(dac_code), 128'hBEEF);
    rd("R11 misaligned reads 0", 5'h11, 32'h0);

    // R7 wrap
    wr(5'h18, 32'h0);
    reg_addr = 5'h18;
    for (int n = 0; n < 2048; n++) begin
      cmd(2'b01, 1);
      repeat (5) step();
    end
    rd("R7 wrap to 0", 5'h18, 32'd0);
    cmd(2'b01, 1);
    repeat (5) step();
    rd("R7 after wrap", 5'h18, 32'd1);

    repeat (3) step();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule